// File: doc/BRIEF.md
# SPI Register Access Port

This block is an SPI slave through which an external host reads and writes a bank of 24-bit registers inside the chip. The host pulls the active-low select low and clocks out a frame. The frame opens with a control byte that holds a word count, then an address byte with read and write flags. Data words follow, 24 bits each, most significant byte first. SCK idles low. SDI is taken on the rising edge and SDO moves on the falling edge. The host may stop SCK between any two bytes for as long as it likes.

SCK, SDI and the select are brought into the system clock through two-flop synchronisers. Edges are detected in the system clock domain, so the system clock must run at least eight times faster than SCK. Toward the core the block has a single-cycle read strobe and write strobe, which share one address. Read data is taken from the core in the same cycle as the read strobe. SDO comes with an output-enable, and the pad is released whenever that enable is low.

The frame logic has five states. IDLE holds while the select is high. CTRL receives the control byte, ADDR receives the address byte, and DATA moves data words. DONE ignores SCK once the last word has moved. The transitions are:
- IDLE to CTRL on select low.
- CTRL to ADDR after 8 bits.
- ADDR to DATA after 8 bits.
- DATA to DONE after the final word.
- Any state to IDLE on select high.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, and while the select is high, `sdo_oe`, `reg_rd` and `reg_wr` are all low.
- R2: Bits travel MSB first and data bytes go most significant first. The control byte carries the word count in bits [7:4], and its bits [3:0] are ignored. In the address byte, bits [7:2] are the register address, bit 1 is the read flag and bit 0 is the write flag. When both flags are set, the frame is a read.
- R3: A write frame gives exactly one `reg_wr` pulse per complete 24-bit word. The pulse comes only after the 24th bit of that word, with `reg_wdata` equal to the word received.
- R4: In a read frame, `reg_rd` pulses once for each word. The fetched word's MSB is on `sdo` before the first data rising edge. While enabled, `sdo` changes only after a falling SCK edge or a word reload.
- R5: A word count N moves N+1 words. The address steps by one per word and wraps modulo 64.
- R6: After the last word, further SCK activity in the same frame causes no access and leaves `sdo_oe` low.
- R7: SCK may pause for any time between bytes without changing the result.
- R8: A select high at any point aborts the frame. `sdo_oe` drops, a partial word is never written, and the next frame starts cleanly.
- R9: `sdo_oe` is high only during the data words of a read frame. It stays low in the header and in write frames.
- R10: An address byte with neither flag set produces no read or write strobe and no SDO drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| sdi | input | 1 | Serial data from host |
| ssb | input | 1 | Active-low frame select |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for the SDO pad |
| reg_addr | output | 6 | Register address toward the core |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 24 | Read data from the core, valid while `reg_rd` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 24 | Write data toward the core |

## Verification
The assertions watch every cycle for the following properties:
- Strobes last one cycle.
- A write lands only on a detected rising edge.
- Read and write strobes never coincide.
- SDO holds steady between falling edges.
- A synchronised select-high forces IDLE.
- DONE stays silent.

The directed scenarios check things that need the whole frame:
- Actual data values and byte order.
- Burst lengths and address wrap.
- Results being unaffected by SCK pauses.
- No write on an aborted partial word.
- Ignored trailing bytes.
- Where the output-enable is active within a frame.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int REG_DATA_W = 24;
    localparam int REG_ADDR_W = 6;
    localparam int WORD_CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } frame_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_in[i];
                sync_q <= meta_q;
            end
        end
        assign d_sync[i] = sync_q;
    end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (clear)   sr_q <= '0;
        else if (load)    sr_q <= load_val;
        else if (shift)   sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_reg_pkg::*;
#(
    parameter int DATA_W = REG_DATA_W,
    parameter int ADDR_W = REG_ADDR_W,
    parameter int CNT_W  = WORD_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              ssb,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int BYTES_PER_WORD = DATA_W / 8;
    localparam int BIDX_W         = $clog2(BYTES_PER_WORD);
    localparam int ACC_W          = DATA_W - 8;

    // synchronised pins: [2]=select, [1]=data in, [0]=clock
    logic [2:0] pin_sync;
    logic       sck_d;
    logic       sck_rise, sck_fall, sdi_q, ssb_q;

    spi_pin_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   ({ssb, sdi, sck}),
        .d_sync (pin_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= pin_sync[0];
    end

    assign sck_rise = pin_sync[0] & ~sck_d;
    assign sck_fall = ~pin_sync[0] & sck_d;
    assign sdi_q    = pin_sync[1];
    assign ssb_q    = pin_sync[2];

    frame_state_e          state, nstate;
    logic [2:0]            bit_cnt;
    logic [BIDX_W-1:0]     byte_idx;
    logic [CNT_W-1:0]      words_left;
    logic [6:0]            rx_sr;
    logic [ACC_W-1:0]      word_acc;
    logic                  rd_mode, wr_mode;
    logic                  step_pend;
    logic                  pend_shift;
    logic                  active, byte_done, word_done;
    logic [7:0]            byte_val;

    assign active    = !ssb_q && (state == ST_CTRL || state == ST_ADDR || state == ST_DATA);
    assign byte_done = active && sck_rise && (bit_cnt == 3'd7);
    assign word_done = byte_done && (state == ST_DATA)
                       && (byte_idx == BIDX_W'(BYTES_PER_WORD - 1));
    assign byte_val  = {rx_sr, sdi_q};

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (!ssb_q)   nstate = ST_CTRL;
            ST_CTRL: if (byte_done) nstate = ST_ADDR;
            ST_ADDR: if (byte_done) nstate = ST_DATA;
            ST_DATA: if (word_done && words_left == '0) nstate = ST_DONE;
            ST_DONE: nstate = ST_DONE;
        endcase
        if (ssb_q) nstate = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            byte_idx   <= '0;
            words_left <= '0;
            rx_sr      <= '0;
            word_acc   <= '0;
            rd_mode    <= 1'b0;
            wr_mode    <= 1'b0;
            step_pend  <= 1'b0;
            pend_shift <= 1'b0;
            reg_addr   <= '0;
            reg_rd     <= 1'b0;
            reg_wr     <= 1'b0;
            reg_wdata  <= '0;
        end else begin
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            step_pend <= 1'b0;
            if (ssb_q || state == ST_IDLE) begin
                bit_cnt    <= '0;
                byte_idx   <= '0;
                pend_shift <= 1'b0;
                rd_mode    <= 1'b0;
                wr_mode    <= 1'b0;
            end else begin
                if (active && sck_rise) begin
                    rx_sr   <= {rx_sr[5:0], sdi_q};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done && state == ST_CTRL) begin
                    words_left <= byte_val[7 -: CNT_W];
                end
                if (byte_done && state == ST_ADDR) begin
                    reg_addr <= byte_val[ADDR_W+1:2];
                    rd_mode  <= byte_val[1];
                    wr_mode  <= byte_val[0] & ~byte_val[1];
                    reg_rd   <= byte_val[1];
                    byte_idx <= '0;
                end
                if (byte_done && state == ST_DATA) begin
                    word_acc <= {word_acc[ACC_W-9:0], byte_val};
                    if (word_done) begin
                        byte_idx  <= '0;
                        reg_wr    <= wr_mode;
                        reg_wdata <= {word_acc, byte_val};
                        if (words_left != '0) begin
                            words_left <= words_left - 1'b1;
                            step_pend  <= 1'b1;
                        end
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                if (step_pend) begin
                    reg_addr <= reg_addr + 1'b1;
                    reg_rd   <= rd_mode;
                end
                if (state == ST_DATA && sck_rise && !word_done) pend_shift <= 1'b1;
                else if (sck_fall)                               pend_shift <= 1'b0;
            end
        end
    end

    spi_tx_shift #(.W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ssb_q),
        .load     (reg_rd),
        .load_val (reg_rdata),
        .shift    (sck_fall && pend_shift && state == ST_DATA),
        .msb      (sdo)
    );

    assign sdo_oe = (state == ST_DATA) && rd_mode && !ssb_q;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
    import spi_reg_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         ssb_q,
    input logic         sck_rise,
    input logic         sck_fall,
    input frame_state_e state,
    input logic         sdo,
    input logic         sdo_oe,
    input logic         reg_rd,
    input logic         reg_wr
);
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R3
    AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(sck_rise)); // R3
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R4
    AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(sck_fall) && !$past(reg_rd)) |-> $stable(sdo)); // R4
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ssb_q |=> (state == ST_IDLE)); // R8
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr)); // R10
    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_DONE) |-> (!reg_wr && !reg_rd && !sdo_oe)); // R6
endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ssb_q    (ssb_q),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .state    (state),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr)
);

// File: tb/test_spi_reg_port.sv
`timescale 1ns/1ps
module test_spi_reg_port;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, sdi = 1'b0, ssb = 1'b1;
    logic        sdo, sdo_oe;
    logic [5:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [23:0] reg_rdata, reg_wdata;

    always #2.5 clk = ~clk;

    spi_reg_port i_spi_reg_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .ssb(ssb),
        .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
    );

    logic [23:0] bank [64];
    int wr_cnt = 0, rd_cnt = 0;
    assign reg_rdata = bank[reg_addr];
    always @(posedge clk) begin
        if (reg_wr) begin
            bank[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    int n_chk = 0, n_bad = 0;
    int oe_hdr = 0, oe_dat = 0;
    bit in_data = 0;
    logic [23:0] tx_words [16];
    logic [23:0] rx_words [16];

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic xfer(input logic [7:0] tb, input int nbits, output logic [7:0] rb);
        rb = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = tb[i];
            idle(HALF);
            rb[i] = sdo;
            if (sdo_oe) begin if (in_data) oe_dat++; else oe_hdr++; end
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [3:0] cnt, input logic [5:0] a, input logic rd, input logic wr,
                         input int nbytes, input int pbits, input int gap);
        logic [7:0] rb;
        oe_hdr = 0; oe_dat = 0; in_data = 0;
        ssb = 1'b0;
        idle(4);
        xfer({cnt, 4'b0101}, 8, rb);
        idle(gap);
        xfer({a, rd, wr}, 8, rb);
        idle(gap);
        in_data = 1;
        for (int k = 0; k < nbytes; k++) begin
            xfer(tx_words[k/3][23-8*(k%3) -: 8], 8, rb);
            rx_words[k/3][23-8*(k%3) -: 8] = rb;
            idle(gap);
        end
        if (pbits > 0) xfer(tx_words[nbytes/3][23-8*(nbytes%3) -: 8], pbits, rb);
        idle(4);
        ssb = 1'b1;
        in_data = 0;
        idle(8);
    endtask

    task automatic t_reset;
        chk(sdo_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1 reset outputs", {21'd0, sdo_oe, reg_wr, reg_rd}, 24'd0);
    endtask

    task automatic t_single_write;
        int w0 = wr_cnt;
        tx_words[0] = 24'hA5C33C;
        frame(4'd0, 6'h17, 1'b0, 1'b1, 3, 0, 0);
        chk(bank[6'h17] == 24'hA5C33C, "R2 R3 single write data", bank[6'h17], 24'hA5C33C);
        chk(wr_cnt - w0 == 1, "R3 one strobe per word", 24'(wr_cnt - w0), 24'd1);
        chk(oe_hdr + oe_dat == 0, "R9 no drive in write frame", 24'(oe_hdr + oe_dat), 24'd0);
        chk(sdo_oe == 0, "R1 idle after frame", {23'd0, sdo_oe}, 24'd0);
    endtask

    task automatic t_single_read;
        int r0 = rd_cnt;
        bank[6'h0A] = 24'h5A0F81;
        tx_words[0] = 24'h000000;
        frame(4'd0, 6'h0A, 1'b1, 1'b0, 3, 0, 0);
        chk(rx_words[0] == 24'h5A0F81, "R2 R4 single read data", rx_words[0], 24'h5A0F81);
        chk(rd_cnt - r0 == 1, "R4 one read strobe", 24'(rd_cnt - r0), 24'd1);
        chk(oe_dat == 24 && oe_hdr == 0, "R9 drive only in data", 24'(oe_dat + 100 * oe_hdr), 24'd24);
    endtask

    task automatic t_burst_write;
        int w0 = wr_cnt;
        bank[6'h01] = 24'h0BEEF0;
        tx_words[0] = 24'h111111; tx_words[1] = 24'h222222; tx_words[2] = 24'h333333;
        frame(4'd2, 6'h3E, 1'b0, 1'b1, 9, 0, 0);
        chk(bank[6'h3E] == 24'h111111, "R5 burst word0", bank[6'h3E], 24'h111111);
        chk(bank[6'h3F] == 24'h222222, "R5 burst word1", bank[6'h3F], 24'h222222);
        chk(bank[6'h00] == 24'h333333, "R5 burst wrap word2", bank[6'h00], 24'h333333);
        chk(bank[6'h01] == 24'h0BEEF0, "R5 burst length", bank[6'h01], 24'h0BEEF0);
        chk(wr_cnt - w0 == 3, "R3 R5 strobe count", 24'(wr_cnt - w0), 24'd3);
    endtask

    task automatic t_burst_read;
        for (int i = 0; i < 4; i++) begin
            bank[6'h20 + i] = 24'hC00000 + 24'(i * 24'h010203);
            tx_words[i] = '0;
        end
        frame(4'd3, 6'h20, 1'b1, 1'b0, 12, 0, 0);
        for (int i = 0; i < 4; i++)
            chk(rx_words[i] == 24'hC00000 + 24'(i * 24'h010203), "R4 R5 burst read word",
                rx_words[i], 24'hC00000 + 24'(i * 24'h010203));
        chk(oe_dat == 96, "R9 burst drive span", 24'(oe_dat), 24'd96);
    endtask

    task automatic t_pause;
        tx_words[0] = 24'h13579B;
        frame(4'd0, 6'h05, 1'b0, 1'b1, 3, 0, 300);
        chk(bank[6'h05] == 24'h13579B, "R7 paused write", bank[6'h05], 24'h13579B);
        frame(4'd0, 6'h05, 1'b1, 1'b0, 3, 0, 300);
        chk(rx_words[0] == 24'h13579B, "R7 paused read", rx_words[0], 24'h13579B);
    endtask

    task automatic t_abort;
        int w0 = wr_cnt;
        bank[6'h30] = 24'h777777;
        tx_words[0] = 24'hDEAD01;
        frame(4'd0, 6'h30, 1'b0, 1'b1, 2, 7, 0);
        chk(bank[6'h30] == 24'h777777, "R3 R8 no write on 23 bits", bank[6'h30], 24'h777777);
        chk(wr_cnt == w0, "R8 no strobe on abort", 24'(wr_cnt - w0), 24'd0);
        frame(4'd0, 6'h30, 1'b1, 1'b0, 1, 3, 0);
        chk(sdo_oe == 0, "R8 drive released on abort", {23'd0, sdo_oe}, 24'd0);
        tx_words[0] = 24'h0C0FFE;
        frame(4'd0, 6'h30, 1'b0, 1'b1, 3, 0, 0);
        chk(bank[6'h30] == 24'h0C0FFE, "R8 clean restart", bank[6'h30], 24'h0C0FFE);
    endtask

    task automatic t_extra;
        int w0 = wr_cnt;
        bank[6'h11] = 24'h454545;
        tx_words[0] = 24'h9ABCDE; tx_words[1] = 24'h112233;
        frame(4'd0, 6'h10, 1'b0, 1'b1, 6, 0, 0);
        chk(bank[6'h10] == 24'h9ABCDE, "R6 first word kept", bank[6'h10], 24'h9ABCDE);
        chk(bank[6'h11] == 24'h454545, "R6 extra bytes ignored", bank[6'h11], 24'h454545);
        chk(wr_cnt - w0 == 1, "R6 single strobe", 24'(wr_cnt - w0), 24'd1);
        bank[6'h12] = 24'h606060;
        tx_words[0] = '0; tx_words[1] = '0;
        frame(4'd0, 6'h12, 1'b1, 1'b0, 6, 0, 0);
        chk(oe_dat == 24, "R6 no drive after last word", 24'(oe_dat), 24'd24);
    endtask

    task automatic t_noflag;
        int w0 = wr_cnt, r0 = rd_cnt;
        bank[6'h08] = 24'h0F0F0F;
        tx_words[0] = 24'hFFFFFF;
        frame(4'd0, 6'h08, 1'b0, 1'b0, 3, 0, 0);
        chk(wr_cnt == w0 && rd_cnt == r0, "R10 no strobes", 24'(wr_cnt - w0 + rd_cnt - r0), 24'd0);
        chk(bank[6'h08] == 24'h0F0F0F, "R10 bank untouched", bank[6'h08], 24'h0F0F0F);
        chk(oe_dat + oe_hdr == 0, "R10 no drive", 24'(oe_dat + oe_hdr), 24'd0);
    endtask

    task automatic t_both;
        int w0 = wr_cnt;
        bank[6'h09] = 24'h2468AC;
        tx_words[0] = 24'h000001;
        frame(4'd0, 6'h09, 1'b1, 1'b1, 3, 0, 0);
        chk(rx_words[0] == 24'h2468AC, "R2 read priority data", rx_words[0], 24'h2468AC);
        chk(wr_cnt == w0 && bank[6'h09] == 24'h2468AC, "R2 read priority no write", bank[6'h09], 24'h2468AC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) bank[i] = 24'(i * 24'h030507);
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(5);
        t_single_write();
        t_single_read();
        t_burst_write();
        t_burst_read();
        t_pause();
        t_abort();
        t_extra();
        t_noflag();
        t_both();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule